// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 64-bit fixed-point system time. On every reference tick it adds a programmable increment instead of one. The integer nanoseconds therefore sit in the upper bits of the counter. Logic outside the block recovers them with a plain right shift by the amount shown on `ns_shift`. Software trims the clock rate by rewriting the increment. A trim of p parts per billion moves the increment by base·|p|/10^9, up or down with the sign of p. Software can also load either 32-bit half of the time directly.

The link-speed input picks the default increment and shift. The block loads them once, in the first cycle after reset is released. The codes are: none and fast share one default, mid uses a reference period ten times longer, and slow one a hundred times longer. A parameter selects one of two variants. The wide variant has a 31-bit increment field. The narrow variant has a 24-bit increment field plus an 8-bit period field. The period field sets how many ticks pass between additions.

Reading the low time word captures the high word in a shadow register. A low-then-high read pair therefore stays coherent while the counter runs.

Top module: `tod_counter`

## Requirements
- R1: After reset, both time words read zero, and a high-word read returns zero.
- R2: One cycle after reset release, the increment takes a default chosen by `link_speed`: code 1 (slow) 0x50000000, code 2 (mid) 0x40000000, codes 0 and 3 (fast or no link) 0x66666666. In the narrow variant the value is shifted right by 7 and placed in bits 23:0, and the period field in bits 31:24 is set to 1.
- R3: `ns_shift` shows 21 for slow, 24 for mid and 28 for fast or no link. The narrow variant shows each value minus 7.
- R4: A tick that causes an addition adds the current increment to the 64-bit time. With no tick and no time write, the time holds.
- R5: Writing address 2 replaces the increment. A tick in the same cycle still uses the old increment. The wide variant keeps bits 30:0 and reads bit 31 back as 0. The narrow variant keeps bits 23:0 as the increment and bits 31:24 as the period, and clears its tick count.
- R6: Writing address 0 replaces the low word, and writing address 1 replaces the high word. The other half is unchanged, and the counter does not advance in that cycle.
- R7: Reading address 0 returns the live low word and, at the clock edge, captures the high word into a shadow. Reading address 1 returns that shadow. Reading address 3 returns 0.
- R8: In the narrow variant with period P greater than 1, the increment is added once every P ticks. When P is 0 or 1, it is added on every tick.
- R9: The time wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| link_speed | input | 2 | Speed code that selects the default increment |
| ref_tick | input | 1 | Reference tick enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 low time, 1 high time (shadow), 2 increment |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| ns_shift | output | 6 | Right shift that converts the time to nanoseconds |

## Verification
Read data is combinational, so the bench samples `reg_rdata` one time step after it sets the address, before the next edge. The shadow capture then happens at that edge. Time and increment writes, like ticks, take effect at the edge where they are sampled. The bench drops its strobes after that edge and expects the new value from the next read. Defaults appear three edges after reset release: two for the reset synchronizer and one for the load. The bench waits six cycles before its first read. Every expected value comes from a 64-bit arithmetic model of each variant, including the narrow variant's period count.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [1:0] SPD_NONE = 2'd0;
  localparam logic [1:0] SPD_SLOW = 2'd1;
  localparam logic [1:0] SPD_MID  = 2'd2;
  localparam logic [1:0] SPD_FAST = 2'd3;

  localparam logic [1:0] ADR_LO  = 2'd0;
  localparam logic [1:0] ADR_HI  = 2'd1;
  localparam logic [1:0] ADR_INC = 2'd2;

  localparam int NARROW_CUT = 7;

  function automatic logic [31:0] base_inc(input logic [1:0] spd);
    case (spd)
      SPD_SLOW: base_inc = 32'h5000_0000;
      SPD_MID:  base_inc = 32'h4000_0000;
      default:  base_inc = 32'h6666_6666;
    endcase
  endfunction

  function automatic logic [5:0] base_shift(input logic [1:0] spd);
    case (spd)
      SPD_SLOW: base_shift = 6'd21;
      SPD_MID:  base_shift = 6'd24;
      default:  base_shift = 6'd28;
    endcase
  endfunction
endpackage

// File: rtl/tod_inc_ctrl.sv
module tod_inc_ctrl
  import tod_pkg::*;
#(
  parameter bit NARROW = 1'b0,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed,
  input  logic              tick,
  input  logic              inc_we,
  input  logic [WORD_W-1:0] inc_wdata,
  output logic              step,
  output logic [WORD_W-1:0] inc_val,
  output logic [WORD_W-1:0] inc_rdback,
  output logic [5:0]        shift
);
  localparam int INC_W = NARROW ? 24 : 31;
  localparam int CUT   = NARROW ? NARROW_CUT : 0;
  localparam int PER_W = WORD_W - 24;

  logic             init_q, init_d;
  logic [INC_W-1:0] inc_q, inc_d;
  logic [1:0]       spd_q, spd_d;

  always_comb begin
    init_d = init_q;
    inc_d  = inc_q;
    spd_d  = spd_q;
    if (!init_q) begin
      init_d = 1'b1;
      inc_d  = INC_W'(base_inc(speed) >> CUT);
      spd_d  = speed;
    end else if (inc_we) begin
      inc_d = inc_wdata[INC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      inc_q  <= '0;
      spd_q  <= SPD_NONE;
    end else begin
      init_q <= init_d;
      inc_q  <= inc_d;
      spd_q  <= spd_d;
    end
  end

  assign inc_val = WORD_W'(inc_q);
  assign shift   = base_shift(spd_q) - 6'(CUT);

  generate
    if (NARROW) begin : g_narrow
      logic [PER_W-1:0] per_q, per_d, cnt_q, cnt_d;
      logic             due;

      assign due = (per_q <= PER_W'(1)) || (cnt_q == per_q - PER_W'(1));

      always_comb begin
        per_d = per_q;
        cnt_d = cnt_q;
        if (!init_q) begin
          per_d = PER_W'(1);
          cnt_d = '0;
        end else if (inc_we) begin
          per_d = inc_wdata[WORD_W-1:24];
          cnt_d = '0;
        end else if (tick) begin
          cnt_d = due ? '0 : cnt_q + PER_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          per_q <= '0;
          cnt_q <= '0;
        end else begin
          per_q <= per_d;
          cnt_q <= cnt_d;
        end
      end

      assign step       = init_q & tick & due;
      assign inc_rdback = {per_q, inc_q};

      // R8
      period_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) || (cnt_q < per_q));
    end else begin : g_wide
      assign step       = init_q & tick;
      assign inc_rdback = {1'b0, inc_q};
    end
  endgenerate

  // R5
  inc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_we && init_q) |=> (inc_q == $past(inc_wdata[INC_W-1:0])));

  // R2
  init_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> init_q);
endmodule

// File: rtl/tod_time_acc.sv
module tod_time_acc #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [WORD_W-1:0]   inc,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                rd_lo,
  output logic [2*WORD_W-1:0] time_o,
  output logic [WORD_W-1:0]   shadow_o
);
  localparam int TIME_W = 2 * WORD_W;

  logic [TIME_W-1:0] time_q, time_d;
  logic [WORD_W-1:0] shadow_q, shadow_d;
  logic              time_en, shadow_en;

  assign time_en   = wr_lo | wr_hi | step;
  assign shadow_en = rd_lo;

  always_comb begin
    time_d = time_q;
    if (wr_lo)      time_d[WORD_W-1:0]      = wdata;
    else if (wr_hi) time_d[TIME_W-1:WORD_W] = wdata;
    else if (step)  time_d = time_q + TIME_W'(inc);
    shadow_d = time_q[TIME_W-1:WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (time_en)   time_q   <= time_d;
      if (shadow_en) shadow_q <= shadow_d;
    end
  end

  assign time_o   = time_q;
  assign shadow_o = shadow_q;

  // R4
  hold_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_lo && !wr_hi) |=> $stable(time_q));

  // R6
  write_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (time_q[TIME_W-1:WORD_W] == $past(wdata)) &&
              (time_q[WORD_W-1:0] == $past(time_q[WORD_W-1:0])));

  // R6
  write_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (time_q[WORD_W-1:0] == $past(wdata)) &&
              (time_q[TIME_W-1:WORD_W] == $past(time_q[TIME_W-1:WORD_W])));

  // R7
  shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (shadow_q == $past(time_q[TIME_W-1:WORD_W])));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter bit NARROW = 1'b0,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [1:0]        link_speed,
  input  logic              ref_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [5:0]        ns_shift
);
  logic [1:0]          rst_sync_q;
  logic                rst_n;
  logic                step;
  logic [WORD_W-1:0]   inc_val, inc_rdback, shadow;
  logic [2*WORD_W-1:0] time_now;
  logic                wr_lo, wr_hi, wr_inc, rd_lo;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign wr_lo  = reg_wr && (reg_addr == ADR_LO);
  assign wr_hi  = reg_wr && (reg_addr == ADR_HI);
  assign wr_inc = reg_wr && (reg_addr == ADR_INC);
  assign rd_lo  = reg_rd && (reg_addr == ADR_LO);

  tod_inc_ctrl #(.NARROW(NARROW), .WORD_W(WORD_W)) u_inc (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed     (link_speed),
    .tick      (ref_tick),
    .inc_we    (wr_inc),
    .inc_wdata (reg_wdata),
    .step      (step),
    .inc_val   (inc_val),
    .inc_rdback(inc_rdback),
    .shift     (ns_shift)
  );

  tod_time_acc #(.WORD_W(WORD_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .inc     (inc_val),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wdata   (reg_wdata),
    .rd_lo   (rd_lo),
    .time_o  (time_now),
    .shadow_o(shadow)
  );

  always_comb begin
    case (reg_addr)
      ADR_LO:  reg_rdata = time_now[WORD_W-1:0];
      ADR_HI:  reg_rdata = shadow;
      ADR_INC: reg_rdata = inc_rdback;
      default: reg_rdata = '0;
    endcase
  end

  // R7
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata == '0));
endmodule

// File: tb/tod_counter_bench.sv
module tod_counter_bench;
  logic        clk = 1'b0;
  logic        arst_n;
  logic [1:0]  link_speed;
  logic        ref_tick, reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] rdata_w, rdata_n;
  logic [5:0]  shift_w, shift_n;

  int checks = 0;
  int errors = 0;

  longint unsigned tw, tn;
  logic [31:0] iw, in_n, pn, cn;

  always #5 clk = ~clk;

  tod_counter #(.NARROW(1'b0)) u_tod_counter (
    .clk(clk), .arst_n(arst_n), .link_speed(link_speed), .ref_tick(ref_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_w), .ns_shift(shift_w));

  tod_counter #(.NARROW(1'b1)) u_tod_narrow (
    .clk(clk), .arst_n(arst_n), .link_speed(link_speed), .ref_tick(ref_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_n), .ns_shift(shift_n));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dflt(input logic [1:0] s);
    case (s)
      2'd1: dflt = 32'h5000_0000;
      2'd2: dflt = 32'h4000_0000;
      default: dflt = 32'h6666_6666;
    endcase
  endfunction

  function automatic logic [5:0] dshift(input logic [1:0] s);
    case (s)
      2'd1: dshift = 6'd21;
      2'd2: dshift = 6'd24;
      default: dshift = 6'd28;
    endcase
  endfunction

  task automatic model_tick();
    tw = tw + longint'(iw);
    if (pn <= 1 || cn == pn - 1) begin
      tn = tn + longint'(in_n);
      cn = 0;
    end else cn = cn + 1;
  endtask

  task automatic model_inc(input logic [31:0] d);
    iw = {1'b0, d[30:0]};
    in_n = {8'd0, d[23:0]};
    pn = {24'd0, d[31:24]};
    cn = 0;
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    arst_n = 1'b0; link_speed = s;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (6) @(negedge clk);
    tw = 0; tn = 0; iw = dflt(s); in_n = dflt(s) >> 7; pn = 1; cn = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] w, output logic [31:0] n);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1; w = rdata_w; n = rdata_n;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; ref_tick = tk;
    @(posedge clk); #1;
    reg_wr = 1'b0; ref_tick = 1'b0;
    if (a == 2'd2) begin
      if (tk) model_tick();
      model_inc(d);
    end else if (a == 2'd0) begin
      tw[31:0] = d; tn[31:0] = d;
    end else if (a == 2'd1) begin
      tw[63:32] = d; tn[63:32] = d;
    end
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(posedge clk); #1; ref_tick = 1'b0;
      model_tick();
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic check_time(input string req);
    logic [31:0] lw, ln, hw, hn;
    rd(2'd0, lw, ln);
    rd(2'd1, hw, hn);
    check({req, " wide lo"}, lw, tw[31:0]);
    check({req, " wide hi"}, hw, tw[63:32]);
    check({req, " narrow lo"}, ln, tn[31:0]);
    check({req, " narrow hi"}, hn, tn[63:32]);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b, a2, b2;
    longint unsigned trim;
    arst_n = 1'b0; link_speed = 2'd0; ref_tick = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = '0;

    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      check_time("R1");
      rd(2'd2, a, b);
      check("R2 wide inc", a, dflt(2'(s)));
      check("R2 narrow inc", b, {8'd1, 24'(dflt(2'(s)) >> 7)});
      check("R3 wide shift", shift_w, dshift(2'(s)));
      check("R3 narrow shift", shift_n, dshift(2'(s)) - 6'd7);
      ticks(5 + s, s);
      check_time("R4");
    end

    // R5 trim by +100000 ppb of the fast base, written with a same-cycle tick
    trim = 64'h6666_6666 + (64'h6666_6666 * 64'd100000) / 64'd1000000000;
    wr(2'd2, trim[31:0], 1'b1);
    rd(2'd2, a, b);
    check("R5 wide inc", a, {1'b0, trim[30:0]});
    check("R5 narrow inc", b, trim[31:0]);
    check_time("R5 same-cycle tick");
    // negative trim of narrow base, period 1
    trim = 64'h00CC_CCCC - (64'h00CC_CCCC * 64'd250000) / 64'd1000000000;
    wr(2'd2, {8'd1, trim[23:0]}, 1'b0);
    ticks(9, 1);
    check_time("R5 trimmed rate");

    // R6 write high with tick: no advance
    wr(2'd1, 32'h0000_0005, 1'b1);
    check_time("R6 hi write");
    wr(2'd0, 32'hFFFF_FFF0, 1'b1);
    check_time("R6 lo write");

    // R7 coherent read across a carry
    wr(2'd2, 32'h0100_0100, 1'b0);
    rd(2'd0, a, b);
    check("R7 lo wide", a, 32'hFFFF_FFF0);
    ticks(1, 0);
    rd(2'd1, a2, b2);
    check("R7 shadow wide", a2, 32'h5);
    check("R7 shadow narrow", b2, 32'h5);
    check_time("R7 after carry");
    rd(2'd3, a, b);
    check("R7 addr3", {a, b}, 64'h0);

    // R8 narrow period of 3
    wr(2'd2, {8'd3, 24'h000100}, 1'b0);
    ticks(7, 0);
    check_time("R8 period 3");
    wr(2'd2, {8'd0, 24'h000010}, 1'b0);
    ticks(4, 2);
    check_time("R8 period 0");

    // R9 wrap
    wr(2'd1, 32'hFFFF_FFFF, 1'b0);
    wr(2'd0, 32'hFFFF_FFF8, 1'b0);
    wr(2'd2, {8'd1, 24'h000010}, 1'b0);
    ticks(2, 0);
    check_time("R9 wrap");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule